// File: doc/BRIEF.md
# Keyed Watchdog with Early-Warning Timer

This peripheral holds two 16-bit down-counters behind a byte-wide register port. The first is an early-warning timer. It reloads itself each time it runs out and latches an interrupt status bit, so software hears about trouble while there is still time to act. The second is the watchdog proper. When it runs out it emits a reset pulse and then stays dead until the system reset clears it. Software keeps the watchdog alive by writing a fixed key byte, 0x5C, to a key register, but only while key matching is enabled.

Both counters advance on single-cycle tick enables. These come from a shared prescaler, which is fed by a reference tick derived from the system clock (one reference tick every `REF_DIV` clocks, standing in for a 32.768 kHz reference). The prescaler offers full rate, one thirty-second of it, or one thousand and twenty-fourth of it. The watchdog can take either the prescaled tick or the raw reference tick.

Setup can be frozen field by field with sticky lock bits. A two-bit stop handshake in the control register can halt the watchdog. Observation addresses give read-only views of both live counts.

Top module: `kwdt_top`

## Requirements
- R1: After reset: config reads 0x00, prescaler 0x00, control 0x00, both reload values 0xFFFF, both counters start from 0xFFFF, `warn_irq` and `wdog_rst` are low.
- R2: A reference tick occurs every `REF_DIV` clocks. Prescaler code 1 (address 0x02) passes every 32nd reference tick and code 2 every 1024th. Codes 0 and 3 pass every reference tick.
- R3: The early-warning counter decrements on each prescaled tick. A tick that finds it at zero reloads it from the reload value (high byte at 0x03, low byte at 0x04) and sets the status, so status sets recur every (reload+1) ticks.
- R4: `warn_irq` is the level of the status bit, readable at control bit 1. Writing 1 to control bit 1 clears it. An expiry in the same cycle wins over the clear.
- R5: Writing 1 to control bit 0 (address 0x05) loads the early-warning counter from its reload value at once.
- R6: With config bit 5 set, writing 0x5C to address 0x07 loads the watchdog counter from its reload value (low 0x06, high 0x09). Any other value, or 0x5C with bit 5 clear, leaves the counter unchanged.
- R7: Config bit 4 set makes the watchdog count prescaled ticks. Clear, it counts raw reference ticks.
- R8: A running watchdog tick that finds the count at zero raises `wdog_rst` for exactly one clock, in the following cycle. The count then holds at zero and ignores the key until reset.
- R9: The watchdog is halted while control bits 4 (stop permitted) and 5 (stop request) are both set. Bit 5 alone does not halt it.
- R10: Config locks: bit 3 freezes the watchdog reload bytes, bit 2 the early-warning reload bytes, bit 1 the prescaler code, and bit 0 the config register itself.
- R11: Addresses 0x40/0x41 read the early-warning count low/high, and 0x60/0x61 read the watchdog count low/high. Configuration registers read back their stored values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 7 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| warn_irq | output | 1 | Early-warning status level |
| wdog_rst | output | 1 | One-cycle watchdog reset pulse |

## Verification
The assertions check these properties on every cycle:
- The reset pulse lasts one cycle.
- An expired watchdog stays at zero.
- A counter never moves without a tick or a load.
- A locked config or reload register never changes.
- A halted watchdog keeps its count.
- An expiry always raises the interrupt.

Only the bench scenarios can show the time-based behaviour. That covers exact timer periods for every prescaler code, the delay from a key write to the reset pulse, which source the watchdog uses, and that wrong keys have no effect. All of these are measured against periods that the bench computes itself.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int AW    = 7;
  localparam int CNT_W = 16;
  localparam int PS_W  = 10;

  localparam logic [AW-1:0] A_CFG  = 7'h01;
  localparam logic [AW-1:0] A_PSC  = 7'h02;
  localparam logic [AW-1:0] A_T1H  = 7'h03;
  localparam logic [AW-1:0] A_T1L  = 7'h04;
  localparam logic [AW-1:0] A_CTRL = 7'h05;
  localparam logic [AW-1:0] A_WDL  = 7'h06;
  localparam logic [AW-1:0] A_KEY  = 7'h07;
  localparam logic [AW-1:0] A_WDH  = 7'h09;
  localparam logic [AW-1:0] A_T1OL = 7'h40;
  localparam logic [AW-1:0] A_T1OH = 7'h41;
  localparam logic [AW-1:0] A_WDOL = 7'h60;
  localparam logic [AW-1:0] A_WDOH = 7'h61;

  localparam logic [7:0] KEY_BYTE = 8'h5C;

  // config bit positions
  localparam int CB_KEYEN  = 5;
  localparam int CB_WDSRC  = 4;
  localparam int CB_LK_WD  = 3;
  localparam int CB_LK_T1  = 2;
  localparam int CB_LK_PS  = 1;
  localparam int CB_LK_CFG = 0;

  // control bit positions
  localparam int XB_T1LD  = 0;
  localparam int XB_STS   = 1;
  localparam int XB_STPOK = 4;
  localparam int XB_STOP  = 5;

  // prescaler code -> mask of reference-tick counter bits that must all be set
  function automatic logic [PS_W-1:0] div_mask(input logic [1:0] code);
    case (code)
      2'd1:    div_mask = PS_W'(10'h01F);
      2'd2:    div_mask = PS_W'(10'h3FF);
      default: div_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/kwdt_tickgen.sv
module kwdt_tickgen #(
  parameter int REF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       ref_tick,
  output logic       pre_tick
);
  import kwdt_pkg::*;
  localparam int REF_W = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REF_DIV - 1);

  logic [REF_W-1:0] ref_cnt;
  logic [PS_W-1:0]  ps_cnt;
  logic [PS_W-1:0]  mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ref_cnt <= '0;
    else if (ref_cnt == REF_LAST) ref_cnt <= '0;
    else                       ref_cnt <= ref_cnt + 1'b1;
  end

  assign ref_tick = (ref_cnt == REF_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ps_cnt <= '0;
    else if (ref_tick) ps_cnt <= ps_cnt + 1'b1;
  end

  assign mask     = div_mask(code);
  assign pre_tick = ref_tick && ((ps_cnt & mask) == mask);

  generate
    if (REF_DIV > 1) begin : g_gap
      // R2
      ref_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_tick |=> !ref_tick);
    end
  endgenerate
endmodule

// File: rtl/kwdt_downcnt.sv
module kwdt_downcnt #(
  parameter int         W    = 16,
  parameter logic [W-1:0] INIT = '1,
  parameter bit         HOLD = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         fire,
  output logic         held
);
  logic at_zero;
  logic step;

  assign at_zero = (count == '0);
  assign step    = tick && run && !held;
  assign fire    = step && at_zero && !load;

  generate
    if (HOLD) begin : g_hold
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   held_q <= 1'b0;
        else if (fire) held_q <= 1'b1;
      end
      assign held = held_q;
      // R8
      hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (held && count == '0));
    end else begin : g_free
      assign held = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count <= INIT;
    else if (load && !held)    count <= load_val;
    else if (fire)             count <= HOLD ? count : load_val;
    else if (step && !at_zero) count <= count - 1'b1;
  end

  // R3
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int REF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [6:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       warn_irq,
  output logic       wdog_rst
);
  import kwdt_pkg::*;

  logic [5:0]       cfg_q;
  logic [1:0]       psc_q;
  logic [CNT_W-1:0] t1_rld_q, wd_rld_q;
  logic             stop_ok_q, stop_req_q, sts_q, rst_q;

  logic ref_tick, pre_tick, wd_tick;
  logic wr_cfg, wr_psc, wr_t1h, wr_t1l, wr_wdl, wr_wdh, wr_ctrl;
  logic t1_load, sts_clr, key_hit, wd_run;
  logic [CNT_W-1:0] t1_cnt, wd_cnt;
  logic t1_fire, wd_fire, t1_held, wd_held;

  // write decode with per-field locks
  assign wr_cfg  = bus_wr && bus_addr == A_CFG  && !cfg_q[CB_LK_CFG];
  assign wr_psc  = bus_wr && bus_addr == A_PSC  && !cfg_q[CB_LK_PS];
  assign wr_t1h  = bus_wr && bus_addr == A_T1H  && !cfg_q[CB_LK_T1];
  assign wr_t1l  = bus_wr && bus_addr == A_T1L  && !cfg_q[CB_LK_T1];
  assign wr_wdl  = bus_wr && bus_addr == A_WDL  && !cfg_q[CB_LK_WD];
  assign wr_wdh  = bus_wr && bus_addr == A_WDH  && !cfg_q[CB_LK_WD];
  assign wr_ctrl = bus_wr && bus_addr == A_CTRL;
  assign t1_load = wr_ctrl && bus_wdata[XB_T1LD];
  assign sts_clr = wr_ctrl && bus_wdata[XB_STS];
  assign key_hit = bus_wr && bus_addr == A_KEY && bus_wdata == KEY_BYTE && cfg_q[CB_KEYEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      psc_q      <= '0;
      t1_rld_q   <= '1;
      wd_rld_q   <= '1;
      stop_ok_q  <= 1'b0;
      stop_req_q <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= bus_wdata[5:0];
      if (wr_psc) psc_q <= bus_wdata[1:0];
      if (wr_t1h) t1_rld_q[15:8] <= bus_wdata;
      if (wr_t1l) t1_rld_q[7:0]  <= bus_wdata;
      if (wr_wdh) wd_rld_q[15:8] <= bus_wdata;
      if (wr_wdl) wd_rld_q[7:0]  <= bus_wdata;
      if (wr_ctrl) begin
        stop_ok_q  <= bus_wdata[XB_STPOK];
        stop_req_q <= bus_wdata[XB_STOP];
      end
    end
  end

  kwdt_tickgen #(.REF_DIV(REF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .code(psc_q),
    .ref_tick(ref_tick), .pre_tick(pre_tick)
  );

  assign wd_tick = cfg_q[CB_WDSRC] ? pre_tick : ref_tick;
  assign wd_run  = !(stop_ok_q && stop_req_q);

  kwdt_downcnt #(.W(CNT_W), .INIT('1), .HOLD(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .run(1'b1),
    .load(t1_load), .load_val(t1_rld_q),
    .count(t1_cnt), .fire(t1_fire), .held(t1_held)
  );

  kwdt_downcnt #(.W(CNT_W), .INIT('1), .HOLD(1'b1)) u_wd (
    .clk(clk), .rst_n(rst_n), .tick(wd_tick), .run(wd_run),
    .load(key_hit), .load_val(wd_rld_q),
    .count(wd_cnt), .fire(wd_fire), .held(wd_held)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      if (t1_fire)      sts_q <= 1'b1;
      else if (sts_clr) sts_q <= 1'b0;
      rst_q <= wd_fire;
    end
  end

  assign warn_irq = sts_q;
  assign wdog_rst = rst_q;

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {2'b00, cfg_q};
      A_PSC:   bus_rdata = {6'b0, psc_q};
      A_T1H:   bus_rdata = t1_rld_q[15:8];
      A_T1L:   bus_rdata = t1_rld_q[7:0];
      A_CTRL:  bus_rdata = {2'b00, stop_req_q, stop_ok_q, 2'b00, sts_q, 1'b0};
      A_WDL:   bus_rdata = wd_rld_q[7:0];
      A_WDH:   bus_rdata = wd_rld_q[15:8];
      A_T1OL:  bus_rdata = t1_cnt[7:0];
      A_T1OH:  bus_rdata = t1_cnt[15:8];
      A_WDOL:  bus_rdata = wd_cnt[7:0];
      A_WDOH:  bus_rdata = wd_cnt[15:8];
      default: bus_rdata = 8'h00;
    endcase
  end

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_rst |=> !wdog_rst);
  // R10
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CB_LK_CFG] |=> $stable(cfg_q));
  // R10
  wd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[CB_LK_WD] |=> $stable(wd_rld_q));
  // R4
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_fire |=> warn_irq);
  // R9
  wd_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_run && !key_hit) |=> $stable(wd_cnt));
  // R8
  held_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_held |-> !wd_fire);
endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;
  localparam int REF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [6:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       warn_irq, wdog_rst;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  kwdt_top #(.REF_DIV(REF)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .warn_irq(warn_irq), .wdog_rst(wdog_rst)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int div_of(input int code);
    if (code == 1) return 32;
    if (code == 2) return 1024;
    return 1;
  endfunction

  function automatic int t1_period(input int code, input int rld);
    return (rld + 1) * REF * div_of(code);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output int d);
    bus_addr = a; #1; d = int'(bus_rdata);
  endtask

  task automatic rd16(input logic [6:0] alo, output int d);
    int lo, hi;
    rd(alo, lo); rd(alo + 7'd1, hi);
    d = (hi << 8) | lo;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_irq(output int t);
    int k = 0;
    @(negedge clk);
    while (!warn_irq && k < 40000) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic wait_rst(input int limit, output int t);
    int k = 0;
    t = -1;
    while (k < limit) begin
      @(negedge clk);
      if (wdog_rst) begin t = cyc; break; end
      k++;
    end
  endtask

  task automatic measure(input int code, input int rld, input string req);
    int ta, tb;
    wr(7'h02, 8'(code));
    wr(7'h03, 8'(rld >> 8));
    wr(7'h04, 8'(rld));
    wr(7'h05, 8'h33);          // reload, clear, keep watchdog halted
    wait_irq(ta);
    wr(7'h05, 8'h32);
    wait_irq(tb);
    chk(req, tb - ta, t1_period(code, rld));
    wr(7'h05, 8'h32);
  endtask

  initial begin : main
    int v, t, t0, pulses;
    void'($urandom(32'd20240611));
    do_reset();

    // R1 reset state
    rd(7'h01, v); chk("R1 cfg", v, 0);
    rd(7'h02, v); chk("R1 psc", v, 0);
    rd(7'h05, v); chk("R1 ctrl", v, 0);
    rd(7'h03, v); chk("R1 t1 reload hi", v, 8'hFF);
    rd(7'h04, v); chk("R1 t1 reload lo", v, 8'hFF);
    rd(7'h06, v); chk("R1 wd reload lo", v, 8'hFF);
    rd(7'h09, v); chk("R1 wd reload hi", v, 8'hFF);
    rd(7'h41, v); chk("R1 t1 count hi", v, 8'hFF);
    rd(7'h61, v); chk("R1 wd count hi", v, 8'hFF);
    chk("R1 irq", int'(warn_irq), 0);
    chk("R1 rst", int'(wdog_rst), 0);

    // R9 / R6: halt watchdog, then probe the key
    wr(7'h05, 8'h30);
    wr(7'h01, 8'h20);
    wr(7'h06, 8'h34);
    wr(7'h09, 8'h12);
    rd16(7'h60, t0);
    repeat (30) @(negedge clk);
    rd16(7'h60, v); chk("R9 halted count stable", v, t0);
    for (int i = 0; i < 20; i++) begin
      logic [7:0] k;
      k = 8'($urandom());
      if (k == 8'h5C) k = 8'h5D;
      wr(7'h07, k);
    end
    rd16(7'h60, v); chk("R6 wrong key no effect", v, t0);
    wr(7'h07, 8'h5C);
    rd16(7'h60, v); chk("R6 key reload", v, 16'h1234);
    wr(7'h06, 8'h55); wr(7'h09, 8'h00);
    wr(7'h01, 8'h00);
    wr(7'h07, 8'h5C);
    rd16(7'h60, v); chk("R6 key disabled", v, 16'h1234);
    wr(7'h01, 8'h20);
    wr(7'h07, 8'h5C);
    rd16(7'h60, v); chk("R6 key re-enabled", v, 16'h0055);
    rd(7'h05, v); chk("R11 ctrl readback", v, 8'h30);
    wr(7'h05, 8'h20);            // request without permission
    repeat (40) @(negedge clk);
    rd16(7'h60, v); chk("R9 stop needs permit", int'(v < 16'h0055), 1);
    wr(7'h05, 8'h30);
    rd16(7'h60, t0);
    repeat (20) @(negedge clk);
    rd16(7'h60, v); chk("R9 halted again", v, t0);

    // R5 immediate reload of early-warning counter
    wr(7'h03, 8'h00); wr(7'h04, 8'h03);
    wr(7'h05, 8'h31);
    rd16(7'h40, v); chk("R5 reload load", v, 3);

    // R3 / R2 periods for every prescaler code
    measure(0, 3, "R3 period code0");
    measure(1, 3, "R2 period code1");
    measure(2, 3, "R2 period code2");
    measure(3, 3, "R2 period code3");
    for (int i = 0; i < 4; i++) measure(0, 1 + int'($urandom_range(6)), "R3 random reload");

    // R4 level status and clear
    wr(7'h02, 8'h00); wr(7'h04, 8'h02); wr(7'h05, 8'h33);
    wait_irq(t);
    repeat (40) @(negedge clk);
    chk("R4 irq level held", int'(warn_irq), 1);
    rd(7'h05, v); chk("R4 status bit", (v >> 1) & 1, 1);
    wr(7'h02, 8'h02);            // slow ticks so clear is not raced
    wr(7'h05, 8'h32);
    chk("R4 irq cleared", int'(warn_irq), 0);

    // R8 expiry with prescaled source
    do_reset();
    wr(7'h01, 8'h30); wr(7'h06, 8'h05); wr(7'h09, 8'h00);
    wr(7'h07, 8'h5C); t0 = cyc;
    wait_rst(2000, t);
    chk_rng("R8 expiry delay", t - t0, 22, 25);
    @(negedge clk);
    chk("R8 single pulse", int'(wdog_rst), 0);
    rd16(7'h60, v); chk("R8 count zero", v, 0);
    wr(7'h07, 8'h5C);
    rd16(7'h60, v); chk("R8 key ignored after expiry", v, 0);
    pulses = 0;
    repeat (80) begin @(negedge clk); if (wdog_rst) pulses++; end
    chk("R8 no further pulse", pulses, 0);

    // R7 raw source ignores prescaler
    do_reset();
    wr(7'h01, 8'h20); wr(7'h02, 8'h01); wr(7'h06, 8'h05); wr(7'h09, 8'h00);
    wr(7'h07, 8'h5C); t0 = cyc;
    wait_rst(2000, t);
    chk_rng("R7 raw source", t - t0, 22, 25);

    // R7 prescaled source with code 1
    do_reset();
    wr(7'h01, 8'h30); wr(7'h02, 8'h01); wr(7'h06, 8'h05); wr(7'h09, 8'h00);
    wr(7'h07, 8'h5C); t0 = cyc;
    wait_rst(2000, t);
    chk_rng("R7 prescaled source", t - t0, 642, 769);

    // R10 locks
    do_reset();
    wr(7'h02, 8'h01);
    wr(7'h01, 8'h08);
    wr(7'h06, 8'h12);
    rd(7'h06, v); chk("R10 wd reload locked", v, 8'hFF);
    wr(7'h04, 8'h07);
    rd(7'h04, v); chk("R11 t1 reload readback", v, 8'h07);
    wr(7'h01, 8'h0C);
    wr(7'h04, 8'h09);
    rd(7'h04, v); chk("R10 t1 reload locked", v, 8'h07);
    wr(7'h01, 8'h0E);
    wr(7'h02, 8'h02);
    rd(7'h02, v); chk("R10 psc locked", v, 1);
    wr(7'h01, 8'h0F);
    for (int i = 0; i < 8; i++) wr(7'h01, 8'($urandom()));
    rd(7'h01, v); chk("R10 cfg self lock", v, 8'h0F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule